// File: doc/BRIEF.md
# Channel Conversion and Start-Threshold FIFO

This block sits between the parallel sample interface of an audio port and its serial shifter. Sample words enter through a valid/ready handshake, optionally pass through a channel converter, and are stored in a word FIFO. The converter either folds a stereo pair into one word or expands one mono word into a pair. If both conversions are enabled, stereo-to-mono takes priority.

The consumer side is held back until the FIFO holds more complete frames than a start threshold, counted in frames of `chans_i` words. The threshold is clamped so it can always be reached in the FIFO. Once streaming has begun, `start_o` stays high while data remains. Running dry under a read request and writing into a full FIFO are each recorded in a sticky flag. A soft reset empties the FIFO and clears every flag.

Top module: `chconv_fifo`

## Requirements
- R1: After `rst_ni` or a one-cycle `soft_rst_i`, the FIFO is empty, the converter restarts at the first word of a pair, and `start_o`, `ovf_o`, `udf_o` and `out_valid_o` are low.
- R2: With both conversions disabled, every accepted word is stored once, and words leave on `out_data_o` in arrival order.
- R3: With `s2m_en_i` high, each two accepted words (first = channel 0, second = channel 1) store one word. The `s2m_mode_i` value selects the stored word: 0 stores channel 0, 1 stores channel 1, and 2 or 3 stores the average. The average is the signed DW+1 bit sum shifted right one place arithmetically, with no rounding.
- R4: With `m2s_en_i` high and `s2m_en_i` low, each accepted word stores two words: the word itself, then a second word. The second word is zero when `m2s_mode_i` is 0 and a copy of the first when it is 1.
- R5: `out_valid_o` stays low until `start_o` is high. `start_o` rises one cycle after the stored word count first reaches (effective threshold + 1) × channels, that is, when stored frames exceed the threshold.
- R6: The effective threshold is the smaller of `thresh_i` and floor(DEPTH / channels) − 1. A `chans_i` of 0 counts as 1, and a value above MAX_CH counts as MAX_CH.
- R7: Once high, `start_o` stays high while the FIFO drains, even below the threshold. It falls only on soft reset or when `out_ready_i` is high while the FIFO is empty. That event also sets `udf_o`.
- R8: `in_ready_o` is low whenever the FIFO holds DEPTH words. If `in_valid_i` is high in such a cycle, the word is dropped and `ovf_o` is set.
- R9: `ovf_o` and `udf_o` stay high until a soft reset or `rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous clear of FIFO, converter and flags |
| chans_i | input | CW | Channels per frame after conversion |
| thresh_i | input | TW | Start threshold in frames |
| s2m_en_i | input | 1 | Enable stereo-to-mono folding |
| s2m_mode_i | input | 2 | 0 ch0, 1 ch1, 2/3 average |
| m2s_en_i | input | 1 | Enable mono-to-stereo expansion |
| m2s_mode_i | input | 1 | 0 zero fill, 1 copy |
| in_data_i | input | DW | Incoming sample word |
| in_valid_i | input | 1 | Incoming word valid |
| in_ready_o | output | 1 | Block can accept a word |
| out_data_o | output | DW | Outgoing sample word |
| out_valid_o | output | 1 | Outgoing word valid |
| out_ready_i | input | 1 | Consumer requests a word |
| start_o | output | 1 | Enough frames buffered; streaming active |
| ovf_o | output | 1 | Sticky overflow |
| udf_o | output | 1 | Sticky underflow |

## Verification
The bench builds the block with its defaults: 16-bit words, a 64-word FIFO and up to 16 channels. With 16 channels the clamp lands exactly on a full FIFO, so the same fill reaches the clamped start point, the full stall and the overflow drop. A 3-channel setting makes the clamp fall one word short of full, which checks the floor in the frame limit. The 16-bit width lets directed average cases hit both signed extremes alongside random pairs.

// File: rtl/chconv_pkg.sv
package chconv_pkg;
  typedef enum logic [1:0] {
    S2M_CH0  = 2'd0,
    S2M_CH1  = 2'd1,
    S2M_AVG  = 2'd2,
    S2M_AVG2 = 2'd3
  } s2m_mode_e;

  typedef enum logic {
    M2S_ZERO = 1'b0,
    M2S_COPY = 1'b1
  } m2s_mode_e;
endpackage

// File: rtl/chconv_conv.sv
module chconv_conv
  import chconv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          s2m_en_i,
  input  s2m_mode_e     s2m_mode_i,
  input  logic          m2s_en_i,
  input  m2s_mode_e     m2s_mode_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic          full_i,
  output logic          push_o,
  output logic [DW-1:0] push_data_o
);
  logic          phase_q;
  logic [DW-1:0] hold_q;
  logic [DW:0]   sum;
  logic [DW-1:0] mix;
  logic          accept;

  assign sum = {hold_q[DW-1], hold_q} + {in_data_i[DW-1], in_data_i};

  always_comb begin
    unique case (s2m_mode_i)
      S2M_CH0: mix = hold_q;
      S2M_CH1: mix = in_data_i;
      default: mix = sum[DW:1];  // arithmetic halve, truncating
    endcase
  end

  always_comb begin
    in_ready_o  = !full_i;
    push_o      = 1'b0;
    push_data_o = in_data_i;
    if (s2m_en_i) begin
      push_o      = phase_q && in_valid_i && !full_i;
      push_data_o = mix;
    end else if (m2s_en_i) begin
      if (!phase_q) begin
        push_o = in_valid_i && !full_i;
      end else begin
        in_ready_o  = 1'b0;
        push_o      = !full_i;
        push_data_o = hold_q;
      end
    end else begin
      push_o = in_valid_i && !full_i;
    end
  end

  assign accept = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      hold_q  <= '0;
    end else if (clr_i) begin
      phase_q <= 1'b0;
      hold_q  <= '0;
    end else if (s2m_en_i) begin
      if (accept) begin
        phase_q <= !phase_q;
        if (!phase_q) hold_q <= in_data_i;
      end
    end else if (m2s_en_i) begin
      if (!phase_q && accept) begin
        phase_q <= 1'b1;
        hold_q  <= (m2s_mode_i == M2S_COPY) ? in_data_i : '0;
      end else if (phase_q && !full_i) begin
        phase_q <= 1'b0;
      end
    end else begin
      phase_q <= 1'b0;
    end
  end
endmodule

// File: rtl/chconv_store.sv
module chconv_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            push_i,
  input  logic [DW-1:0]   data_i,
  input  logic            pop_i,
  output logic [DW-1:0]   rd_data_o,
  output logic [CNTW-1:0] count_o,
  output logic            full_o,
  output logic            empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic          wr, rd;

  assign full_o    = (count_o == CNTW'(DEPTH));
  assign empty_o   = (count_o == '0);
  assign wr        = push_i && !full_o;
  assign rd        = pop_i && !empty_o;
  assign rd_data_o = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_o  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_o  <= '0;
    end else begin
      if (wr) wr_ptr_q <= nxt(wr_ptr_q);
      if (rd) rd_ptr_q <= nxt(rd_ptr_q);
      if (wr && !rd)      count_o <= count_o + 1'b1;
      else if (rd && !wr) count_o <= count_o - 1'b1;
    end
  end

  a_r8_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r2_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/chconv_thresh.sv
module chconv_thresh #(
  parameter int DEPTH  = 64,
  parameter int MAX_CH = 16,
  localparam int CW    = $clog2(MAX_CH + 1),
  localparam int TW    = $clog2(DEPTH),
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0]   chans_i,
  input  logic [TW-1:0]   thresh_i,
  output logic [CNTW-1:0] need_o
);
  int unsigned ch, cap, frames;

  always_comb begin
    if (chans_i == '0)                 ch = 1;
    else if (32'(chans_i) > MAX_CH)    ch = MAX_CH;
    else                               ch = 32'(chans_i);
    cap    = DEPTH / ch;               // frames that fit
    frames = 32'(thresh_i) + 1;
    if (frames > cap) frames = cap;
    need_o = CNTW'(frames * ch);
  end
endmodule

// File: rtl/chconv_fifo.sv
module chconv_fifo
  import chconv_pkg::*;
#(
  parameter int DW     = 16,
  parameter int DEPTH  = 64,
  parameter int MAX_CH = 16,
  localparam int CW    = $clog2(MAX_CH + 1),
  localparam int TW    = $clog2(DEPTH),
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic [CW-1:0] chans_i,
  input  logic [TW-1:0] thresh_i,
  input  logic          s2m_en_i,
  input  logic [1:0]    s2m_mode_i,
  input  logic          m2s_en_i,
  input  logic          m2s_mode_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  output logic [DW-1:0] out_data_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic          start_o,
  output logic          ovf_o,
  output logic          udf_o
);
  logic            full, empty, push, pop, dry_read;
  logic [DW-1:0]   push_data;
  logic [CNTW-1:0] count, need;

  chconv_conv #(.DW(DW)) u_conv (
    .clk_i, .rst_ni, .clr_i(soft_rst_i),
    .s2m_en_i, .s2m_mode_i(s2m_mode_e'(s2m_mode_i)),
    .m2s_en_i, .m2s_mode_i(m2s_mode_e'(m2s_mode_i)),
    .in_data_i, .in_valid_i, .in_ready_o,
    .full_i(full), .push_o(push), .push_data_o(push_data)
  );

  chconv_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .clr_i(soft_rst_i),
    .push_i(push), .data_i(push_data), .pop_i(pop),
    .rd_data_o(out_data_o), .count_o(count), .full_o(full), .empty_o(empty)
  );

  chconv_thresh #(.DEPTH(DEPTH), .MAX_CH(MAX_CH)) u_thresh (
    .chans_i, .thresh_i, .need_o(need)
  );

  assign out_valid_o = start_o && !empty;
  assign pop         = out_valid_o && out_ready_i;
  assign dry_read    = start_o && empty && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      ovf_o   <= 1'b0;
      udf_o   <= 1'b0;
    end else if (soft_rst_i) begin
      start_o <= 1'b0;
      ovf_o   <= 1'b0;
      udf_o   <= 1'b0;
    end else begin
      if (dry_read)           start_o <= 1'b0;
      else if (count >= need) start_o <= 1'b1;
      if (dry_read)           udf_o   <= 1'b1;
      if (in_valid_i && full) ovf_o   <= 1'b1;
    end
  end

  a_r1_soft_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (count == '0) && !start_o && !ovf_o && !udf_o);
  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !soft_rst_i) |=> ovf_o);
  a_r9_udf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (udf_o && !soft_rst_i) |=> udf_o);
  a_r7_start_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_o) |-> ($past(soft_rst_i) || udf_o));
  a_r6_need_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (need != '0) && (need <= CNTW'(DEPTH)));
endmodule

// File: tb/tb_chconv_fifo.sv
module tb_chconv_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, soft_rst = 0;
  logic [4:0]  chans = 5'd2;
  logic [5:0]  thr = 6'd3;
  logic        s2m_en = 0, m2s_en = 0, m2s_mode = 0;
  logic [1:0]  s2m_mode = 0;
  logic [15:0] in_data = 0, out_data;
  logic        in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic        start, ovf, udf;
  int          n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  chconv_fifo dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .chans_i(chans), .thresh_i(thr),
    .s2m_en_i(s2m_en), .s2m_mode_i(s2m_mode),
    .m2s_en_i(m2s_en), .m2s_mode_i(m2s_mode),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .start_o(start), .ovf_o(ovf), .udf_o(udf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] s2m_ref(input logic [1:0] m, input logic [15:0] a, input logic [15:0] b);
    logic signed [16:0] s;
    s = $signed({a[15], a}) + $signed({b[15], b});
    case (m)
      2'd0: return a;
      2'd1: return b;
      default: return 16'(s >>> 1);
    endcase
  endfunction

  task automatic push(input logic [15:0] w);
    @(negedge clk); in_data = w; in_valid = 1; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk); in_valid = 0;
  endtask

  task automatic pop(output logic [15:0] d);
    @(negedge clk); out_ready = 1; #1;
    while (!out_valid) begin @(negedge clk); #1; end
    d = out_data;
    @(negedge clk); out_ready = 0;
  endtask

  task automatic sreset();
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] d, a, b;
    logic [15:0] q[$];
    void'($urandom(32'h5EED));
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    chk("R1 start", start, 0); chk("R1 ovf", ovf, 0); chk("R1 udf", udf, 0);
    chk("R1 out_valid", out_valid, 0); chk("R1 in_ready", in_ready, 1);

    // R2/R5: pass-through, chans 2, thr 3 -> 8 words needed
    for (int i = 0; i < 7; i++) begin d = 16'($urandom); q.push_back(d); push(d); end
    idle(2);
    chk("R5 start below threshold", start, 0);
    chk("R5 out_valid gated", out_valid, 0);
    d = 16'($urandom); q.push_back(d); push(d);
    chk("R5 start not yet (one cycle delay)", start, 0);
    idle(1);
    chk("R5 start at threshold", start, 1);
    for (int i = 0; i < 8; i++) begin pop(d); chk("R2 order", d, q.pop_front()); end
    chk("R7 start held while empty", start, 1);
    chk("R7 no udf yet", udf, 0);
    @(negedge clk); out_ready = 1; @(negedge clk); out_ready = 0;
    chk("R7 udf on dry read", udf, 1);
    chk("R7 start dropped", start, 0);
    idle(3);
    chk("R9 udf sticky", udf, 1);

    // R1 soft reset, mid-pair converter state
    sreset();
    chk("R1 udf cleared", udf, 0);
    chans = 1; thr = 0; s2m_en = 1; s2m_mode = 0;
    push(16'h1111);
    sreset();
    idle(2);
    chk("R1 fifo empty after soft reset", out_valid, 0);
    push(16'h2222); push(16'h3333);
    pop(d); chk("R1 pair restarts after soft reset", d, 16'h2222);

    // R3 stereo to mono, all modes, random and directed
    for (int m = 0; m < 4; m++) begin
      sreset(); s2m_mode = 2'(m);
      for (int i = 0; i < 12; i++) begin
        a = 16'($urandom); b = 16'($urandom);
        push(a); push(b); pop(d);
        chk("R3 s2m random", d, s2m_ref(2'(m), a, b));
      end
    end
    sreset(); s2m_mode = 2;
    push(16'h7FFF); push(16'h7FFF); pop(d); chk("R3 avg max", d, 16'h7FFF);
    push(16'h8000); push(16'h8000); pop(d); chk("R3 avg min", d, 16'h8000);
    push(16'h0001); push(16'h0000); pop(d); chk("R3 avg truncates +", d, 16'h0000);
    push(16'hFFFD); push(16'h0000); pop(d); chk("R3 avg floors -", d, 16'hFFFE);
    push(16'hFFFF); push(16'h0000); pop(d); chk("R3 avg -1", d, 16'hFFFF);

    // R4 mono to stereo
    s2m_en = 0; m2s_en = 1; chans = 2;
    for (int m = 0; m < 2; m++) begin
      sreset(); m2s_mode = 1'(m);
      for (int i = 0; i < 10; i++) begin
        a = 16'($urandom);
        push(a);
        pop(d); chk("R4 m2s first", d, a);
        pop(d); chk("R4 m2s second", d, (m == 1) ? a : 16'h0000);
      end
    end

    // R6 clamp with 16 channels, R8 full and overflow
    sreset(); m2s_en = 0; chans = 16; thr = 10;
    q.delete();
    for (int i = 0; i < 63; i++) begin d = 16'($urandom); q.push_back(d); push(d); end
    idle(2);
    chk("R6 clamp 16ch not started at 63", start, 0);
    d = 16'($urandom); q.push_back(d); push(d);
    idle(1);
    chk("R6 clamp 16ch started at 64", start, 1);
    chk("R8 in_ready low when full", in_ready, 0);
    @(negedge clk); in_data = 16'hDEAD; in_valid = 1;
    @(negedge clk); in_valid = 0;
    chk("R8 ovf set", ovf, 1);
    for (int i = 0; i < 64; i++) begin pop(d); chk("R8 contents intact", d, q.pop_front()); end
    idle(1);
    chk("R8 dropped word absent", out_valid, 0);
    chk("R7 start held after drain", start, 1);
    chk("R9 ovf sticky", ovf, 1);

    // R6 clamp with 3 channels: floor(64/3)-1 = 20 -> 63 words
    sreset(); chans = 3; thr = 30;
    for (int i = 0; i < 62; i++) push(16'(i));
    idle(2);
    chk("R6 clamp 3ch not started at 62", start, 0);
    push(16'd62);
    idle(1);
    chk("R6 clamp 3ch started at 63", start, 1);

    // R6 zero channels counts as one: thr 2 -> 3 words
    sreset(); chans = 0; thr = 2;
    push(16'd1); push(16'd2); idle(2);
    chk("R6 zero chans not started at 2", start, 0);
    push(16'd3); idle(1);
    chk("R6 zero chans started at 3", start, 1);

    finish_run();
  end
endmodule